// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Write-Collision Detection

This block is a serial peripheral interface unit that sits on a small byte-wide register bus inside a microcontroller-class chip. Software programs a control register, loads a byte into the data register, and the unit shifts that byte out while it shifts a byte in. In master mode the unit drives the serial clock, the select line and the outgoing data. In slave mode it follows a serial clock and a select line that another device drives. One output pin carries outgoing data and one input pin carries incoming data. The pad logic maps these pins to MOSI or MISO according to the mode.

A master transfer begins when software writes the data register while the unit is idle. The serial clock rate comes from a two-bit rate code together with a core clock-mode input, which selects 6-clock or 12-clock timing. When a byte completes, a sticky completion flag is set, and an interrupt request follows if it is enabled. A data write that arrives while a byte is still moving does not touch the transfer. It sets a sticky collision flag instead. Software clears either flag by writing 0 to its status bit.

Register map (2-bit address): 0 = control, 1 = status, 2 = data, 3 reads as 0. Control bits: 7 interrupt enable, 6 unit enable, 5 LSB-first, 4 master, 3 CPOL, 2 CPHA, 1:0 rate code.

Top module: `spi_port`

## Requirements
- R1: After reset the status register reads 0x00, ss_n_o is 1, sck_o is 0 and irq_o is 0.
- R2: In master mode with control bit 6 set, a data write while idle starts a transfer. ss_n_o stays low for the whole transfer and returns high after it ends. The transfer has exactly 8 SCK cycles.
- R3: In master mode the SCK period, in core clocks, is 2, 8, 32 or 64 for rate codes 0 to 3 when core_x6 is 1, and 4, 16, 64 or 128 when core_x6 is 0.
- R4: SCK rests at the level of control bit 3 (CPOL) whenever no transfer runs, including after the eighth cycle.
- R5: With CPHA (control bit 2) at 0, each data bit is valid before the leading SCK edge and is sampled on that edge. With CPHA at 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: Bytes go out and come in MSB first when control bit 5 is 0, and LSB first when it is 1.
- R7: Status bit 7 is set when the eighth bit completes. It stays set until software writes 0 to it. Writing 1 leaves it unchanged.
- R8: A data write during a transfer sets status bit 6, which stays set until software writes 0 to it. That write alters neither the outgoing bits nor the received byte.
- R9: irq_o is 1 exactly when status bit 7, control bit 7 and periph_ie are all 1.
- R10: Reading the data register returns the last received byte.
- R11: In slave mode (control bit 4 at 0), the unit shifts on edges of sck_i while sel_n_i is low, and the rate code has no effect.
- R12: Status bits 5 to 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| core_x6 | input | 1 | 1 = 6-clock core timing, 0 = 12-clock |
| periph_ie | input | 1 | Chip-level peripheral interrupt enable |
| sck_o | output | 1 | Serial clock driven as master |
| sck_i | input | 1 | Serial clock received as slave |
| sel_n_i | input | 1 | Slave select received as slave, active low |
| ss_n_o | output | 1 | Slave select driven as master, active low |
| ser_out | output | 1 | Outgoing serial data |
| ser_in | input | 1 | Incoming serial data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is a data write that lands inside a running byte, so that the collision path runs while the shift engine is busy. The bench selects the slowest rate (12-clock timing, code 3), which makes a byte last 1024 core clocks, and issues the stray write partway through. The scoreboard then confirms that the serial bits and the received byte are still the original ones. Slave mode is the other hard case. There the bench acts as the remote master, driving sck_i slowly enough to pass the input synchronizer, and it reads back what the unit shifted in.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // control register, field order matches bit 7 down to bit 0
    typedef struct packed {
        logic       irq_en;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       core_x6,
    input  logic [1:0] rate,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half;

    // half period in core clocks; 12-clock timing doubles it
    always_comb begin
        unique case (rate)
            2'd0:    half = CNT_W'(1);
            2'd1:    half = CNT_W'(4);
            2'd2:    half = CNT_W'(16);
            default: half = CNT_W'(32);
        endcase
        if (!core_x6) half = half << 1;
        tick  = run && (cnt_q == half - CNT_W'(1));
        cnt_d = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic edge_o
);

    logic [STAGES:0] sr_d, sr_q;

    always_comb begin
        sr_d   = {sr_q[STAGES-1:0], sck_i};
        edge_o = sr_q[STAGES] ^ sr_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW     = 8,
    parameter int CNT_W  = 7,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          core_x6,
    input  logic          periph_ie,
    output logic          sck_o,
    input  logic          sck_i,
    input  logic          sel_n_i,
    output logic          ss_n_o,
    output logic          ser_out,
    input  logic          ser_in,
    output logic          irq_o
);

    localparam int            EW   = $clog2(2 * DW);
    localparam logic [EW-1:0] LAST = EW'(2 * DW - 1);

    typedef struct packed {
        ctrl_t         ctrl;
        logic          busy;
        logic [EW-1:0] ecnt;
        logic          phase;
        logic [DW-1:0] sh;
        logic          smp;
        logic          dout;
        logic [DW-1:0] rx;
        logic          done;
        logic          coll;
    } state_t;

    state_t s_d, s_q;

    logic tick, sedge;
    logic st_done, st_coll, st_busy, st_cpol, st_master;

    function automatic logic first_bit(input logic lsb, input logic [DW-1:0] v);
        return lsb ? v[0] : v[DW-1];
    endfunction

    spi_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.ctrl.master && s_q.busy),
        .core_x6 (core_x6),
        .rate    (s_q.ctrl.rate),
        .tick    (tick)
    );

    spi_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .edge_o (sedge)
    );

    logic          wr_ctrl, wr_stat, wr_data, in_flight, step, lead, bit_in;
    logic [DW-1:0] sh_next;

    always_comb begin
        s_d       = s_q;
        wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
        wr_stat   = bus_wr && (bus_addr == A_STAT);
        wr_data   = bus_wr && (bus_addr == A_DATA);
        in_flight = s_q.ctrl.master ? s_q.busy : (s_q.ecnt != '0);
        step      = s_q.ctrl.master ? (s_q.busy && tick)
                                    : (s_q.ctrl.en && !sel_n_i && sedge);
        lead      = !s_q.ecnt[0];
        bit_in    = s_q.ctrl.cpha ? ser_in : s_q.smp;
        sh_next   = s_q.ctrl.lsb_first ? {bit_in, s_q.sh[DW-1:1]}
                                       : {s_q.sh[DW-2:0], bit_in};

        if (!s_q.ctrl.master && sel_n_i) s_d.ecnt = '0;

        if (wr_ctrl) s_d.ctrl = ctrl_t'(bus_wdata[7:0]);
        if (wr_stat) begin
            s_d.done = s_q.done & bus_wdata[DW-1];
            s_d.coll = s_q.coll & bus_wdata[DW-2];
        end
        if (wr_data) begin
            if (in_flight) begin
                s_d.coll = 1'b1;
            end else if (s_q.ctrl.en) begin
                s_d.sh   = bus_wdata;
                s_d.dout = first_bit(s_q.ctrl.lsb_first, bus_wdata);
                if (s_q.ctrl.master) begin
                    s_d.busy  = 1'b1;
                    s_d.ecnt  = '0;
                    s_d.phase = 1'b0;
                end
            end
        end

        if (step) begin
            s_d.phase = ~s_q.phase;
            s_d.ecnt  = s_q.ecnt + EW'(1);
            if (lead) begin
                s_d.smp = ser_in;
                if (s_q.ctrl.cpha) s_d.dout = first_bit(s_q.ctrl.lsb_first, s_q.sh);
            end else begin
                s_d.sh = sh_next;
                if (!s_q.ctrl.cpha) s_d.dout = first_bit(s_q.ctrl.lsb_first, sh_next);
            end
            if (s_q.ecnt == LAST) begin
                s_d.done  = 1'b1;
                s_d.rx    = sh_next;
                s_d.busy  = 1'b0;
                s_d.ecnt  = '0;
                s_d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        st_done   = s_q.done;
        st_coll   = s_q.coll;
        st_busy   = s_q.busy;
        st_cpol   = s_q.ctrl.cpol;
        st_master = s_q.ctrl.master;
        sck_o     = (s_q.ctrl.master && s_q.busy) ? (s_q.ctrl.cpol ^ s_q.phase)
                                                  : s_q.ctrl.cpol;
        ss_n_o    = !(s_q.ctrl.master && s_q.busy);
        ser_out   = s_q.dout;
        irq_o     = s_q.done && s_q.ctrl.irq_en && periph_ie;
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: bus_rdata = DW'(s_q.ctrl);
            A_STAT: begin
                bus_rdata[DW-1] = s_q.done;
                bus_rdata[DW-2] = s_q.coll;
            end
            A_DATA: bus_rdata = s_q.rx;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          sck_o,
    input logic          ss_n_o,
    input logic          irq_o,
    input logic          periph_ie,
    input logic          cpol,
    input logic          master,
    input logic          done,
    input logic          coll,
    input logic          busy
);

    AST_SS_WHILE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        (master && sck_o != cpol) |-> !ss_n_o); // R2

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (master && ss_n_o) |-> (sck_o == cpol)); // R4

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $fell(busy)) |-> done); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(bus_wr && bus_addr == A_STAT)) |=> done); // R7

    AST_BUSY_WRITE_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        (master && busy && bus_wr && bus_addr == A_DATA) |=> coll); // R8

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !(bus_wr && bus_addr == A_STAT)) |=> coll); // R8

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !bus_wr) |=> (irq_o || !periph_ie)); // R9

    AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[DW-3:0] == '0)); // R12

endmodule

bind spi_port spi_port_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sck_o     (sck_o),
    .ss_n_o    (ss_n_o),
    .irq_o     (irq_o),
    .periph_ie (periph_ie),
    .cpol      (st_cpol),
    .master    (st_master),
    .done      (st_done),
    .coll      (st_coll),
    .busy      (st_busy)
);

// File: tb/spi_port_test.sv
module spi_port_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       core_x6 = 1'b1;
    logic       periph_ie = 1'b0;
    logic       sck_o, ss_n_o, ser_out, irq_o;
    logic       sck_i = 1'b0;
    logic       sel_n_i = 1'b1;
    logic       drv_bit = 1'b0;
    logic       loop_en = 1'b1;
    logic       ser_in;

    assign ser_in = loop_en ? ser_out : drv_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_x6(core_x6),
        .periph_ie(periph_ie), .sck_o(sck_o), .sck_i(sck_i), .sel_n_i(sel_n_i),
        .ss_n_o(ss_n_o), .ser_out(ser_out), .ser_in(ser_in), .irq_o(irq_o)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard state
    logic [7:0] exp_q[$];
    bit  mon_en = 0;
    bit  cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;
    int  lead_cnt = 0, nbits = 0, cyc = 0, first_lead = 0, period = 0;
    logic [7:0] got = '0;
    logic sck_prev = 1'b0, out_prev = 1'b0, ss_prev = 1'b1;

    // monitor: decodes the serial stream at the sample edges
    always @(negedge clk) begin
        cyc++;
        if (mon_en && (!ss_n_o || !ss_prev) && sck_o != sck_prev) begin
            bit is_lead;
            is_lead = (sck_o != cur_cpol);
            if (is_lead) begin
                lead_cnt++;
                if (lead_cnt == 1) first_lead = cyc;
                if (lead_cnt == 2) period = cyc - first_lead;
            end
            if (is_lead != cur_cpha) begin
                got = cur_lsb ? {out_prev, got[7:1]} : {got[6:0], out_prev};
                nbits++;
                if (nbits == 8) begin
                    logic [7:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                    chk("R5/R6 serial byte", got, e);
                    nbits = 0;
                end
            end
        end
        sck_prev = sck_o;
        out_prev = ser_out;
        ss_prev  = ss_n_o;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 2'd1;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (n < 4000 && bus_rdata[7] !== 1'b1) begin
            @(negedge clk); #1; n++;
        end
        chk(req, bus_rdata[7], 1);
    endtask

    function automatic int exp_period(input int rate, input bit x6);
        int b;
        case (rate)
            0: b = 2;
            1: b = 8;
            2: b = 32;
            default: b = 64;
        endcase
        return x6 ? b : 2 * b;
    endfunction

    // driver: push expected byte, configure and start one master transfer
    task automatic run_master(input logic [7:0] ctl, input bit x6, input logic [7:0] tx);
        logic [7:0] v;
        wr(2'd1, 8'h00);
        core_x6 = x6;
        cur_cpol = ctl[3]; cur_cpha = ctl[2]; cur_lsb = ctl[5];
        wr(2'd0, ctl);
        lead_cnt = 0; nbits = 0; period = 0;
        exp_q.push_back(tx);
        wr(2'd2, tx);
        repeat (2) @(negedge clk);
        chk("R2 ss low during transfer", ss_n_o, 0);
        wait_done("R7 done set");
        chk("R2 ss released", ss_n_o, 1);
        chk("R4 sck idle after transfer", sck_o, ctl[3]);
        chk("R2 eight sck cycles", lead_cnt, 8);
        rd(2'd2, v);
        chk("R10 loopback byte", v, tx);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, v);
        chk("R1 status reset", v, 0);
        chk("R1 ss reset", ss_n_o, 1);
        chk("R1 sck reset", sck_o, 0);
        chk("R1 irq reset", irq_o, 0);
        mon_en = 1;

        // basic transfer, then periods over every rate and both core modes
        run_master(8'h50, 1'b1, 8'hA5);
        chk("R9 irq off without enable", irq_o, 0);
        for (int m = 1; m >= 0; m--) begin
            for (int r = 0; r < 4; r++) begin
                run_master(8'h50 | 8'(r), m[0], 8'(8'h11 * (r + 1) + m));
                chk($sformatf("R3 period rate=%0d x6=%0d", r, m), period, exp_period(r, m[0]));
            end
        end

        // polarity, phase and order combinations
        run_master(8'h58, 1'b1, 8'hC3);
        chk("R4 cpol1 idle high", sck_o, 1);
        run_master(8'h54, 1'b1, 8'h3A);
        run_master(8'h5C, 1'b1, 8'h81);
        run_master(8'h70, 1'b1, 8'h4D);
        run_master(8'h7C, 1'b0, 8'hE2);

        // flag clearing
        wr(2'd1, 8'hFF);
        rd(2'd1, v);
        chk("R7 write 1 keeps done", v, 8'h80);
        wr(2'd1, 8'h00);
        rd(2'd1, v);
        chk("R7 write 0 clears done", v, 8'h00);

        // interrupt gating
        periph_ie = 1'b1;
        run_master(8'hD0, 1'b1, 8'h69);
        @(negedge clk);
        chk("R9 irq with all enables", irq_o, 1);
        periph_ie = 1'b0; #1;
        chk("R9 irq gated by periph_ie", irq_o, 0);
        periph_ie = 1'b1;
        wr(2'd1, 8'h00); #1;
        chk("R9 irq drops with flag", irq_o, 0);

        // collision at the slowest rate
        wr(2'd1, 8'h00);
        core_x6 = 1'b0;
        cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
        wr(2'd0, 8'h53);
        lead_cnt = 0; nbits = 0;
        exp_q.push_back(8'h3C);
        wr(2'd2, 8'h3C);
        repeat (200) @(negedge clk);
        wr(2'd2, 8'hFF);
        rd(2'd1, v);
        chk("R8 coll set mid transfer", v, 8'h40);
        wait_done("R8 transfer still completes");
        rd(2'd2, v);
        chk("R8 received byte undisturbed", v, 8'h3C);
        rd(2'd1, v);
        chk("R12 status reserved zero", v, 8'hC0);
        wr(2'd1, 8'h80);
        rd(2'd1, v);
        chk("R8 coll cleared, done kept", v, 8'h80);
        wr(2'd1, 8'h00);

        // slave mode, bench acts as remote master; rate code 3 set but unused
        mon_en = 0;
        loop_en = 0;
        wr(2'd0, 8'h43);
        wr(2'd2, 8'h96);
        sel_n_i = 1'b0;
        repeat (4) @(negedge clk);
        begin
            logic [7:0] seen = '0;
            for (int i = 7; i >= 0; i--) begin
                drv_bit = 8'h5B >> i;
                repeat (8) @(negedge clk);
                seen = {seen[6:0], ser_out};
                sck_i = 1'b1;
                repeat (8) @(negedge clk);
                sck_i = 1'b0;
            end
            chk("R11 slave sends preload", seen, 8'h96);
        end
        repeat (8) @(negedge clk);
        sel_n_i = 1'b1;
        rd(2'd1, v);
        chk("R11 slave done flag", v, 8'h80);
        rd(2'd2, v);
        chk("R11 slave received byte", v, 8'h5B);
        chk("R11 slave drives no sck", sck_o, 0);

        chk("R5 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule